// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block holds the software-visible control and status registers of a small set of descriptor DMA channels behind one 32-bit register bus. Each channel is given an 8 KiB address window. Inside that window the channel keeps its descriptor pointers, its configuration and command words, and its interrupt state: raw events, an enable mask and a write-to-clear acknowledge. The channel also keeps a stream command word and a status word that is built from live state fields.

Writes to the stream command register are decoded by bit masks into one-cycle strobes for an attached descriptor engine, which is not part of this block. The strobes ask the engine to load a data descriptor, load a context descriptor, or start the channel. A write to the command register produces a continue strobe. The engine reports back by rewriting the pointer pair, raising raw interrupt events and flagging end-of-list. Each channel drives a level interrupt while any of its unmasked raw events is set.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset, each channel's status register (offset 0x88) reads 0x101, every other readable register reads 0, every strobe is low and every `irq_o` bit is low.
- R2: The channel index is (bus_addr − BASE) >> 13 and the offset is bus_addr & 0x1FFF. The following registers can be written and then read back: saved-data pointer 0x58, saved-buffer pointer 0x5C, group 0x60, group-down 0x7C, command 0x80, config 0x84 and interrupt mask 0x8C (low 4 bits). The stream command register 0x9C reads back the low 10 bits of the last value written to it. A write to one channel leaves every other channel unchanged.
- R3: Reads of an offset that is not listed, and reads at a channel index of NUM_CH or higher, return 0. Writes to these locations are ignored. Writes to status (0x88), raw interrupt (0x94) and masked interrupt (0x98) are also ignored.
- R4: The status word holds the state code in bits [2:0], the end-of-list flag in bit 5 and the stream source flag in bit 8. The stream source flag is 1 after reset. The state codes are idle = 1, stopped = 2 and running = 4.
- R5: A stream command write decodes the low 10 bits of the written value. If both bits of 0x140 are set, `load_data_o` pulses. If bit 9 (0x200) is set, `load_ctx_o` pulses. Each strobe is high for exactly the one cycle that follows the write.
- R6: A stream command that loads a data descriptor and also has bit 5 (0x20) set starts the channel only while its `client_present` bit is 1. Starting sets the state to running, clears the end-of-list flag and pulses `start_o`. Without a client, the state stays the same and `start_o` stays low.
- R7: An `eng_ptr_wr` pulse copies `eng_ptr_data` into the saved-data pointer and `eng_ptr_buf` into the saved-buffer pointer. If a bus write to either of these registers falls in the same cycle, the engine values win.
- R8: A bit set in `eng_intr_set` sets the matching raw interrupt bit (offset 0x94). Writing the acknowledge register (offset 0x90) clears every raw bit that is 1 in the written value. If a bit is set and acknowledged in the same cycle, the bit stays set. The acknowledge register always reads 0.
- R9: The masked interrupt register (offset 0x98) reads raw AND mask. `irq_o` for a channel is 1 exactly when that channel's masked value is nonzero, starting from the cycle after the change.
- R10: A write to the command register pulses `continue_o` for one cycle only when all of these hold: config bit 0 (enable) is 1, config bit 1 (stop) is 0, the channel is running and a client is present.
- R11: An `eng_eol_set` pulse sets the end-of-list flag; it wins over a start in the same cycle. A config write with bit 1 set while the channel is running moves the channel to stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| bus_rvalid | output | 1 | Marks `bus_rdata` valid |
| client_present | input | NUM_CH | A client is attached to the channel |
| eng_intr_set | input | NUM_CH*INTR_W | Raw interrupt event bits, one group per channel |
| eng_eol_set | input | NUM_CH | Engine reached the end of the descriptor list |
| eng_ptr_wr | input | NUM_CH | Engine rewrites the pointer pair |
| eng_ptr_data | input | 32 | New saved-data pointer |
| eng_ptr_buf | input | 32 | New saved-buffer pointer |
| load_data_o | output | NUM_CH | Load data descriptor strobe |
| load_ctx_o | output | NUM_CH | Load context descriptor strobe |
| start_o | output | NUM_CH | Channel start strobe |
| continue_o | output | NUM_CH | Continue strobe |
| irq_o | output | NUM_CH | Level interrupt per channel |

## Verification
Two pairs of functions can act on the same bit in the same cycle: a software acknowledge and a new engine event on the same raw interrupt bit, and a bus write and an engine update on the same pointer register. The bench drives the bus strobe and the engine pulse on the same falling edge in one cycle. It then reads the raw register and checks that the bit is still set and that the interrupt level matches. It reads back the saved-data pointer and checks that it holds the engine value and not the bus value.

// File: rtl/dma_chan_csr_pkg.sv
package dma_chan_csr_pkg;
  localparam int WIN_SHIFT = 13;
  localparam int OFF_W     = 13;

  localparam logic [OFF_W-1:0] OFF_SDATA  = 13'h058;
  localparam logic [OFF_W-1:0] OFF_SBUF   = 13'h05C;
  localparam logic [OFF_W-1:0] OFF_GRP    = 13'h060;
  localparam logic [OFF_W-1:0] OFF_GRPDN  = 13'h07C;
  localparam logic [OFF_W-1:0] OFF_CMD    = 13'h080;
  localparam logic [OFF_W-1:0] OFF_CFG    = 13'h084;
  localparam logic [OFF_W-1:0] OFF_STAT   = 13'h088;
  localparam logic [OFF_W-1:0] OFF_MASK   = 13'h08C;
  localparam logic [OFF_W-1:0] OFF_ACK    = 13'h090;
  localparam logic [OFF_W-1:0] OFF_RAW    = 13'h094;
  localparam logic [OFF_W-1:0] OFF_MSKD   = 13'h098;
  localparam logic [OFF_W-1:0] OFF_SCMD   = 13'h09C;

  localparam logic [9:0] SC_LOAD_DATA = 10'h140;
  localparam logic [9:0] SC_BURST     = 10'h020;
  localparam logic [9:0] SC_LOAD_CTX  = 10'h200;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd1,
    ST_STOP = 3'd2,
    ST_RUN  = 3'd4
  } chan_state_e;
endpackage

// File: rtl/dma_csr_addr_decode.sv
module dma_csr_addr_decode
  import dma_chan_csr_pkg::*;
#(
  parameter int          NUM_CH = 2,
  parameter logic [31:0] BASE   = 32'h0,
  localparam int         CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [31:0]      addr,
  output logic [CH_W-1:0]  ch_idx,
  output logic [OFF_W-1:0] off,
  output logic             hit
);
  logic [31:0]           rel;
  logic [31-WIN_SHIFT:0] idx_full;

  always_comb begin
    rel      = addr - BASE;
    idx_full = rel[31:WIN_SHIFT];
    off      = rel[OFF_W-1:0];
    hit      = idx_full < (32-WIN_SHIFT)'(NUM_CH);
    ch_idx   = idx_full[CH_W-1:0];
  end
endmodule

// File: rtl/dma_scmd_decode.sv
module dma_scmd_decode
  import dma_chan_csr_pkg::*;
(
  input  logic [9:0] cmd,
  output logic       do_load_data,
  output logic       do_burst,
  output logic       do_load_ctx
);
  always_comb begin
    do_load_data = (cmd & SC_LOAD_DATA) == SC_LOAD_DATA;
    do_burst     = (cmd & SC_BURST) == SC_BURST;
    do_load_ctx  = (cmd & SC_LOAD_CTX) == SC_LOAD_CTX;
  end
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_chan_csr_pkg::*;
#(
  parameter int INTR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  off,
  input  logic [31:0]       wdata,
  input  logic              client,
  input  logic [INTR_W-1:0] intr_set,
  input  logic              eol_set,
  input  logic              ptr_wr,
  input  logic [31:0]       ptr_data,
  input  logic [31:0]       ptr_buf,
  output logic [31:0]       rdata,
  output logic              load_data_o,
  output logic              load_ctx_o,
  output logic              start_o,
  output logic              continue_o,
  output logic              irq_o
);
  logic [31:0]       sdata_q, sbuf_q, grp_q, grpdn_q, cmd_q, cfg_q;
  logic [INTR_W-1:0] mask_q, raw_q;
  logic [9:0]        scmd_q;
  chan_state_e       state_q;
  logic              eol_q, src_q;

  logic ack_wr, mask_wr, cfg_wr, cmd_wr, scmd_wr;
  logic dec_ld, dec_burst, dec_lc, start_go;

  assign ack_wr  = wr_en && (off == OFF_ACK);
  assign mask_wr = wr_en && (off == OFF_MASK);
  assign cfg_wr  = wr_en && (off == OFF_CFG);
  assign cmd_wr  = wr_en && (off == OFF_CMD);
  assign scmd_wr = wr_en && (off == OFF_SCMD);

  dma_scmd_decode u_dec (
    .cmd          (wdata[9:0]),
    .do_load_data (dec_ld),
    .do_burst     (dec_burst),
    .do_load_ctx  (dec_lc)
  );

  assign start_go = scmd_wr && dec_ld && dec_burst && client;

  // register storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdata_q <= '0; sbuf_q <= '0; grp_q <= '0; grpdn_q <= '0;
      cmd_q   <= '0; cfg_q  <= '0; mask_q <= '0; scmd_q <= '0;
    end else begin
      if (wr_en) begin
        case (off)
          OFF_SDATA: sdata_q <= wdata;
          OFF_SBUF:  sbuf_q  <= wdata;
          OFF_GRP:   grp_q   <= wdata;
          OFF_GRPDN: grpdn_q <= wdata;
          OFF_CMD:   cmd_q   <= wdata;
          OFF_CFG:   cfg_q   <= wdata;
          OFF_MASK:  mask_q  <= wdata[INTR_W-1:0];
          OFF_SCMD:  scmd_q  <= wdata[9:0];
          default: ;
        endcase
      end
      if (ptr_wr) begin
        sdata_q <= ptr_data;
        sbuf_q  <= ptr_buf;
      end
    end
  end

  // interrupt raw status: new events win over acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~(ack_wr ? wdata[INTR_W-1:0] : '0)) | intr_set;
  end

  assign irq_o = |(raw_q & mask_q);

  // channel state and end-of-list flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      eol_q   <= 1'b0;
      src_q   <= 1'b1;
    end else begin
      if (start_go) begin
        state_q <= ST_RUN;
        eol_q   <= 1'b0;
      end else if (cfg_wr && wdata[1] && state_q == ST_RUN) begin
        state_q <= ST_STOP;
      end
      if (eol_set) eol_q <= 1'b1;
    end
  end

  // engine strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_data_o <= 1'b0;
      load_ctx_o  <= 1'b0;
      start_o     <= 1'b0;
      continue_o  <= 1'b0;
    end else begin
      load_data_o <= scmd_wr && dec_ld;
      load_ctx_o  <= scmd_wr && dec_lc;
      start_o     <= start_go;
      continue_o  <= cmd_wr && cfg_q[0] && !cfg_q[1] && client && (state_q == ST_RUN);
    end
  end

  always_comb begin
    case (off)
      OFF_SDATA: rdata = sdata_q;
      OFF_SBUF:  rdata = sbuf_q;
      OFF_GRP:   rdata = grp_q;
      OFF_GRPDN: rdata = grpdn_q;
      OFF_CMD:   rdata = cmd_q;
      OFF_CFG:   rdata = cfg_q;
      OFF_STAT:  rdata = {23'b0, src_q, 2'b0, eol_q, 2'b0, state_q};
      OFF_MASK:  rdata = {{(32-INTR_W){1'b0}}, mask_q};
      OFF_RAW:   rdata = {{(32-INTR_W){1'b0}}, raw_q};
      OFF_MSKD:  rdata = {{(32-INTR_W){1'b0}}, raw_q & mask_q};
      OFF_SCMD:  rdata = {22'b0, scmd_q};
      default:   rdata = '0;
    endcase
  end

  // R4: state code is always one of the three legal one-hot values
  p_state_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_q) == 1);

  // R6: a start strobe always comes with a data load and a running channel
  p_start_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (load_data_o && state_q == ST_RUN));

  // R8: acknowledged bits are clear unless re-raised in the same cycle
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> ((raw_q & $past(wdata[INTR_W-1:0]) & ~$past(intr_set)) == '0));

  // R8: every raised event is present in raw status next cycle
  p_set_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|intr_set) |=> ((raw_q & $past(intr_set)) == $past(intr_set)));

  // R9: the interrupt line cannot rise without an event or a mask write
  p_no_spont_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && intr_set == '0 && !mask_wr) |=> !irq_o);

  // R10: continue only follows a command write on a running channel
  p_continue_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    continue_o |-> $past(state_q == ST_RUN && cmd_wr));
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_chan_csr_pkg::*;
#(
  parameter int          NUM_CH = 2,
  parameter int          INTR_W = 4,
  parameter logic [31:0] BASE   = 32'h0,
  localparam int         CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [31:0]              bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic                     bus_rvalid,
  input  logic [NUM_CH-1:0]        client_present,
  input  logic [NUM_CH*INTR_W-1:0] eng_intr_set,
  input  logic [NUM_CH-1:0]        eng_eol_set,
  input  logic [NUM_CH-1:0]        eng_ptr_wr,
  input  logic [31:0]              eng_ptr_data,
  input  logic [31:0]              eng_ptr_buf,
  output logic [NUM_CH-1:0]        load_data_o,
  output logic [NUM_CH-1:0]        load_ctx_o,
  output logic [NUM_CH-1:0]        start_o,
  output logic [NUM_CH-1:0]        continue_o,
  output logic [NUM_CH-1:0]        irq_o
);
  logic [CH_W-1:0]  ch_idx;
  logic [OFF_W-1:0] off;
  logic             hit;
  logic [31:0]      ch_rd [NUM_CH];
  logic [31:0]      rd_sel;

  dma_csr_addr_decode #(.NUM_CH(NUM_CH), .BASE(BASE)) u_adec (
    .addr   (bus_addr),
    .ch_idx (ch_idx),
    .off    (off),
    .hit    (hit)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dma_chan_slot #(.INTR_W(INTR_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (bus_wr && hit && (ch_idx == CH_W'(i))),
      .off         (off),
      .wdata       (bus_wdata),
      .client      (client_present[i]),
      .intr_set    (eng_intr_set[i*INTR_W +: INTR_W]),
      .eol_set     (eng_eol_set[i]),
      .ptr_wr      (eng_ptr_wr[i]),
      .ptr_data    (eng_ptr_data),
      .ptr_buf     (eng_ptr_buf),
      .rdata       (ch_rd[i]),
      .load_data_o (load_data_o[i]),
      .load_ctx_o  (load_ctx_o[i]),
      .start_o     (start_o[i]),
      .continue_o  (continue_o[i]),
      .irq_o       (irq_o[i])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (hit && ch_idx == CH_W'(i)) rd_sel = ch_rd[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_sel : '0;
    end
  end

  // R3: read data outside a mapped channel is zero
  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit) |=> (bus_rdata == '0));
endmodule

// File: tb/dma_chan_csr_bench.sv
`timescale 1ns/1ps
module dma_chan_csr_bench;
  localparam int NC = 2;
  localparam int IW = 4;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_rvalid;
  logic [NC-1:0] client_present = 0, eng_eol_set = 0, eng_ptr_wr = 0;
  logic [NC*IW-1:0] eng_intr_set = 0;
  logic [31:0] eng_ptr_data = 0, eng_ptr_buf = 0;
  logic [NC-1:0] load_data_o, load_ctx_o, start_o, continue_o, irq_o;

  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  dma_chan_csr #(.NUM_CH(NC), .INTR_W(IW)) u_dma_chan_csr (.*);

  typedef struct packed {
    logic        wr;
    logic [31:0] waddr;
    logic [31:0] wdata;
    logic [31:0] raddr;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0058, 32'h1000_0040, 32'h0058, 32'h1000_0040},
    '{1'b1, 32'h005C, 32'h0000_00AB, 32'h005C, 32'h0000_00AB},
    '{1'b1, 32'h0060, 32'h2000_0010, 32'h0060, 32'h2000_0010},
    '{1'b1, 32'h007C, 32'h3000_0020, 32'h007C, 32'h3000_0020},
    '{1'b1, 32'h0084, 32'h0000_0001, 32'h0084, 32'h0000_0001},
    '{1'b1, 32'h008C, 32'h0000_00FF, 32'h008C, 32'h0000_000F},
    '{1'b1, 32'h0090, 32'h0000_000F, 32'h0090, 32'h0000_0000},
    '{1'b1, 32'h0094, 32'h0000_000F, 32'h0094, 32'h0000_0000},
    '{1'b1, 32'h2058, 32'h0000_2222, 32'h2058, 32'h0000_2222},
    '{1'b0, 32'h0000, 32'h0000_0000, 32'h0058, 32'h1000_0040},
    '{1'b1, 32'h0040, 32'h0000_0055, 32'h0040, 32'h0000_0000},
    '{1'b1, 32'h4058, 32'h0000_0001, 32'h4058, 32'h0000_0000},
    '{1'b1, 32'h0088, 32'h0000_00FF, 32'h0088, 32'h0000_0101}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    rd(32'h0088, rv); chk("R1 ch0 status", rv, 32'h101);
    rd(32'h2088, rv); chk("R1 ch1 status", rv, 32'h101);
    rd(32'h0058, rv); chk("R1 saved-data", rv, 0);
    chk("R1 irq", {30'b0, irq_o}, 0);
    chk("R1 strobes", {24'b0, load_data_o, load_ctx_o, start_o, continue_o}, 0);

    // R2/R3/R4/R8: vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].waddr, VECS[i].wdata);
      rd(VECS[i].raddr, rv);
      chk($sformatf("R2/R3 vector %0d", i), rv, VECS[i].exp);
    end

    // R5/R6: stream commands without a client
    wr(32'h009C, 32'h160);
    chk("R5 load_data", {31'b0, load_data_o[0]}, 1);
    chk("R6 no start without client", {31'b0, start_o[0]}, 0);
    rd(32'h0088, rv); chk("R6 state unchanged", rv, 32'h101);
    wr(32'h009C, 32'h100);
    chk("R5 partial mask no load", {31'b0, load_data_o[0]}, 0);
    wr(32'h009C, 32'h200);
    chk("R5 load_ctx", {30'b0, load_ctx_o[0], load_data_o[0]}, 32'h2);
    wr(32'h009C, 32'hFFFF_FF40 | 32'h200);
    chk("R5 both loads", {30'b0, load_ctx_o[0], load_data_o[0]}, 32'h3);
    rd(32'h009C, rv); chk("R2 scmd low10", rv, 32'h340);

    // R6: start with a client
    client_present = 2'b01;
    wr(32'h009C, 32'h160);
    chk("R6 start", {31'b0, start_o[0]}, 1);
    @(negedge clk);
    chk("R5 one-cycle strobe", {31'b0, load_data_o[0]}, 0);
    rd(32'h0088, rv); chk("R4 running", rv, 32'h104);

    // R11: end-of-list, then restart clears it
    @(negedge clk); eng_eol_set = 2'b01;
    @(negedge clk); eng_eol_set = 0;
    rd(32'h0088, rv); chk("R11 eol flag", rv, 32'h124);
    wr(32'h009C, 32'h160);
    rd(32'h0088, rv); chk("R6 start clears eol", rv, 32'h104);

    // R7: engine pointer update wins over a same-cycle bus write
    @(negedge clk);
    bus_wr = 1; bus_addr = 32'h0058; bus_wdata = 32'h1111_1111;
    eng_ptr_wr = 2'b01; eng_ptr_data = 32'hDEAD_0000; eng_ptr_buf = 32'h0000_BEEF;
    @(negedge clk);
    bus_wr = 0; eng_ptr_wr = 0;
    rd(32'h0058, rv); chk("R7 engine wins", rv, 32'hDEAD_0000);
    rd(32'h005C, rv); chk("R7 buf pointer", rv, 32'h0000_BEEF);
    rd(32'h2058, rv); chk("R7 other channel", rv, 32'h0000_2222);

    // R8/R9: interrupts
    wr(32'h008C, 32'h0);
    @(negedge clk); eng_intr_set = 8'h05;
    @(negedge clk); eng_intr_set = 0;
    rd(32'h0094, rv); chk("R8 raw set", rv, 32'h5);
    chk("R9 irq masked off", {31'b0, irq_o[0]}, 0);
    wr(32'h008C, 32'h4);
    chk("R9 irq high", {31'b0, irq_o[0]}, 1);
    rd(32'h0098, rv); chk("R9 masked read", rv, 32'h4);
    wr(32'h0090, 32'h4);
    chk("R9 irq low after ack", {31'b0, irq_o[0]}, 0);
    rd(32'h0094, rv); chk("R8 ack clears", rv, 32'h1);
    wr(32'h008C, 32'h1);
    @(negedge clk);
    bus_wr = 1; bus_addr = 32'h0090; bus_wdata = 32'h1; eng_intr_set = 8'h01;
    @(negedge clk);
    bus_wr = 0; eng_intr_set = 0;
    rd(32'h0094, rv); chk("R8 set wins over ack", rv, 32'h1);
    chk("R9 irq stays", {31'b0, irq_o[0]}, 1);
    rd(32'h0090, rv); chk("R8 ack reads zero", rv, 0);

    // R10/R11: continue and stop
    wr(32'h0080, 32'h1);
    chk("R10 continue", {31'b0, continue_o[0]}, 1);
    wr(32'h0084, 32'h3);
    rd(32'h0088, rv); chk("R11 stopped", rv, 32'h102);
    wr(32'h0080, 32'h1);
    chk("R10 no continue when stopped", {31'b0, continue_o[0]}, 0);
    wr(32'h2080, 32'h1);
    chk("R10 idle channel", {31'b0, continue_o[1]}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule